// File: doc/BRIEF.md
# Link Training Stall Recovery Monitor

This block supervises link bring-up for a serial link controller. When its enable input goes high, it first issues a one-cycle write of the link capability word with the target-speed field forced to the lowest rate. It then raises a training-enable output and starts polling two debug status words on a fixed microsecond interval. It reports link-up once the link is established and no longer training. If the link does not come up within a set number of polls, it reports a failure instead.

During each poll it also looks for a receiver that has stalled while changing rate. In that case the state machine sits in a receiver-lock state and the PHY does not report valid receive data. When it sees this, it performs a read-modify-write on the PHY receiver override register through a simple request/acknowledge register port. The write sets the receive-data-enable and receive-PLL-enable override bits. After a hold time it clears the same two bits with a second read-modify-write, and then polling resumes.

All delays come from a microsecond prescaler derived from a clock-frequency parameter. This lets a short configuration run the same sequence in a few hundred cycles.

Top module: `lt_stall_mon`

## Requirements
- R1: On the first cycle after enable rises, cap_wr pulses high for one cycle with link_cap_out equal to link_cap_in, except that bits [3:0] are 4'd1. train_en rises on the next cycle and stays high while enable is high.
- R2: link_up is set at a poll when dbg_word1 bit 4 is 1 and dbg_word1 bit 29 is 0. If bit 29 is 1 the link is not reported up. Once set, link_up stays high while enable is high.
- R3: Polls are spaced POLL_US microseconds apart. A microsecond is CLK_HZ/1e6 clock cycles, set by a prescaler.
- R4: A stall is declared at a poll only when dbg_word0[5:0] equals 6'h0D and rx_valid is 0. At any other poll no PHY access is made.
- R5: On a stall, the block reads PHY register OVRD_ADDR and writes back the value read with bits 5 and 3 set and all other bits unchanged.
- R6: ovrd_on is high from the end of the setting write until the end of the clearing write. It stays high for about HOLD_US microseconds. The clearing write is a fresh read followed by a write of that value with bits 5 and 3 cleared. Polling then resumes.
- R7: If MAX_POLLS polls pass without link-up, fail is set. It stays high until enable falls. fail and link_up are never both high.
- R8: While enable is low, train_en, link_up, fail, ovrd_on and phy_req are low on the following cycle.
- R9: Once phy_req is high, it stays high with phy_we, phy_addr and phy_wdata stable until phy_ack is seen. phy_addr is always OVRD_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Starts and holds the monitor; low returns it to idle |
| link_cap_in | input | 32 | Current link capability word |
| dbg_word0 | input | 32 | Debug status word, state code in [5:0] |
| dbg_word1 | input | 32 | Debug status word, link bit 4, in-training bit 29 |
| rx_valid | input | 1 | PHY receiver reports valid data |
| phy_ack | input | 1 | PHY register port acknowledge (one-cycle pulse) |
| phy_rdata | input | 16 | PHY register read data, valid with phy_ack |
| cap_wr | output | 1 | One-cycle write strobe for link_cap_out |
| link_cap_out | output | 32 | Capability word with target speed forced to 1 |
| train_en | output | 1 | Link training enable |
| link_up | output | 1 | Link established |
| fail | output | 1 | Link never came up within the poll budget |
| ovrd_on | output | 1 | Receiver override bits are currently asserted |
| phy_req | output | 1 | PHY register port request |
| phy_we | output | 1 | PHY request is a write |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |

## Verification
The bench builds the block with CLK_HZ of 2 MHz, so each microsecond is two clock cycles and the prescaler actually divides. POLL_US is 10, HOLD_US is 40 and MAX_POLLS is 16. With these values a poll occurs roughly every 21 cycles, a full timeout lasts a few hundred cycles, and the override hold lasts about 80 cycles. That makes the timeout path, the complete read-modify-write recovery and the hold duration all reachable and measurable many times within one run.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_CAPW, M_WAIT, M_CHECK, M_SETOV, M_HOLD, M_CLROV, M_DONE
  } mon_state_e;

  typedef enum logic [1:0] {
    P_IDLE, P_READ, P_WRITE
  } rmw_state_e;

  localparam int LINK_BIT     = 4;
  localparam int TRAIN_BIT    = 29;
  localparam int CODE_W       = 6;
  localparam int SPEED_W      = 4;
  localparam int RXDATA_BIT   = 5;
  localparam int RXPLL_BIT    = 3;
endpackage

// File: rtl/lt_us_tick.sv
module lt_us_tick #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PRE = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PRW = (PRE < 2) ? 1 : $clog2(PRE);

  logic [PRW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == PRW'(PRE - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lt_timer.sv
module lt_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lt_phy_rmw.sv
module lt_phy_rmw #(
  parameter int          AW   = 16,
  parameter int          DW   = 16,
  parameter logic [AW-1:0] ADDR = 16'h1005,
  parameter logic [DW-1:0] MASK = 16'h0028
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          start,
  input  logic          set_mode,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_rdata,
  output logic          phy_req,
  output logic          phy_we,
  output logic [AW-1:0] phy_addr,
  output logic [DW-1:0] phy_wdata,
  output logic          done
);
  import lt_pkg::*;

  rmw_state_e st;
  logic       mode_q;

  assign phy_addr = ADDR;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st        <= P_IDLE;
      phy_req   <= 1'b0;
      phy_we    <= 1'b0;
      phy_wdata <= '0;
      mode_q    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        P_IDLE: if (start) begin
          phy_req <= 1'b1;
          phy_we  <= 1'b0;
          mode_q  <= set_mode;
          st      <= P_READ;
        end
        P_READ: if (phy_ack) begin
          phy_we    <= 1'b1;
          phy_wdata <= mode_q ? (phy_rdata | MASK) : (phy_rdata & ~MASK);
          st        <= P_WRITE;
        end
        P_WRITE: if (phy_ack) begin
          phy_req <= 1'b0;
          phy_we  <= 1'b0;
          done    <= 1'b1;
          st      <= P_IDLE;
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lt_stall_mon.sv
module lt_stall_mon #(
  parameter int              CLK_HZ     = 100_000_000,
  parameter int              POLL_US    = 10,
  parameter int              HOLD_US    = 3000,
  parameter int              MAX_POLLS  = 2000,
  parameter int              PHY_AW     = 16,
  parameter int              PHY_DW     = 16,
  parameter logic [PHY_AW-1:0] OVRD_ADDR  = 16'h1005,
  parameter logic [5:0]      STALL_CODE = 6'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [31:0]       link_cap_in,
  input  logic [31:0]       dbg_word0,
  input  logic [31:0]       dbg_word1,
  input  logic              rx_valid,
  input  logic              phy_ack,
  input  logic [PHY_DW-1:0] phy_rdata,
  output logic              cap_wr,
  output logic [31:0]       link_cap_out,
  output logic              train_en,
  output logic              link_up,
  output logic              fail,
  output logic              ovrd_on,
  output logic              phy_req,
  output logic              phy_we,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata
);
  import lt_pkg::*;

  localparam int TMAX = (POLL_US > HOLD_US) ? POLL_US : HOLD_US;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(MAX_POLLS + 1);
  localparam logic [PHY_DW-1:0] OV_MASK =
    (PHY_DW'(1) << RXDATA_BIT) | (PHY_DW'(1) << RXPLL_BIT);

  mon_state_e     state;
  logic [PW-1:0]  poll_cnt;
  logic           us_tick, tmr_zero, tmr_load;
  logic [TW-1:0]  tmr_val;
  logic           rmw_start, rmw_set, rmw_done;
  logic           link_ok, stall_seen, last_poll;

  assign link_ok    = dbg_word1[LINK_BIT] && !dbg_word1[TRAIN_BIT];
  assign stall_seen = (dbg_word0[CODE_W-1:0] == STALL_CODE) && !rx_valid;
  assign last_poll  = (poll_cnt == PW'(MAX_POLLS - 1));

  assign tmr_load = enable && ((state == M_CAPW) || (state == M_CHECK) ||
                    (rmw_done && (state == M_SETOV || state == M_CLROV)));
  assign tmr_val  = (state == M_SETOV) ? TW'(HOLD_US) : TW'(POLL_US);

  assign rmw_set   = (state == M_CHECK);
  assign rmw_start = enable &&
                     (((state == M_CHECK) && !link_ok && !last_poll && stall_seen) ||
                      ((state == M_HOLD) && tmr_zero));

  lt_us_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst(rst), .tick(us_tick)
  );

  lt_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .tick(us_tick), .zero(tmr_zero)
  );

  lt_phy_rmw #(.AW(PHY_AW), .DW(PHY_DW), .ADDR(OVRD_ADDR), .MASK(OV_MASK)) u_rmw (
    .clk(clk), .rst(rst), .abort(!enable), .start(rmw_start), .set_mode(rmw_set),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata), .phy_req(phy_req), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .done(rmw_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= M_IDLE;
      poll_cnt     <= '0;
      cap_wr       <= 1'b0;
      link_cap_out <= '0;
      train_en     <= 1'b0;
      link_up      <= 1'b0;
      fail         <= 1'b0;
      ovrd_on      <= 1'b0;
    end else begin
      cap_wr <= 1'b0;
      if (!enable) begin
        state    <= M_IDLE;
        poll_cnt <= '0;
        train_en <= 1'b0;
        link_up  <= 1'b0;
        fail     <= 1'b0;
        ovrd_on  <= 1'b0;
      end else begin
        case (state)
          M_IDLE: begin
            cap_wr       <= 1'b1;
            link_cap_out <= {link_cap_in[31:SPEED_W], SPEED_W'(1)};
            poll_cnt     <= '0;
            state        <= M_CAPW;
          end
          M_CAPW: begin
            train_en <= 1'b1;
            state    <= M_WAIT;
          end
          M_WAIT: if (tmr_zero) state <= M_CHECK;
          M_CHECK: begin
            if (link_ok) begin
              link_up <= 1'b1;
              state   <= M_DONE;
            end else if (last_poll) begin
              fail  <= 1'b1;
              state <= M_DONE;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              state    <= stall_seen ? M_SETOV : M_WAIT;
            end
          end
          M_SETOV: if (rmw_done) begin
            ovrd_on <= 1'b1;
            state   <= M_HOLD;
          end
          M_HOLD: if (tmr_zero) state <= M_CLROV;
          M_CLROV: if (rmw_done) begin
            ovrd_on <= 1'b0;
            state   <= M_WAIT;
          end
          M_DONE: state <= M_DONE;
          default: state <= M_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lt_stall_mon_chk.sv
module lt_stall_mon_chk #(
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16,
  parameter logic [PHY_AW-1:0] OVRD_ADDR = 16'h1005
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [31:0]       link_cap_in,
  input logic              cap_wr,
  input logic [31:0]       link_cap_out,
  input logic              train_en,
  input logic              link_up,
  input logic              fail,
  input logic              ovrd_on,
  input logic              phy_req,
  input logic              phy_we,
  input logic              phy_ack,
  input logic [PHY_AW-1:0] phy_addr,
  input logic [PHY_DW-1:0] phy_wdata
);
  a_r1_cap_speed: assert property (@(posedge clk) disable iff (rst)
    cap_wr |-> (link_cap_out[3:0] == 4'd1) &&
               (link_cap_out[31:4] == $past(link_cap_in[31:4])));

  a_r1_train_after_cap: assert property (@(posedge clk) disable iff (rst)
    $rose(train_en) |-> $past(cap_wr));

  a_r2_up_sticky: assert property (@(posedge clk) disable iff (rst)
    link_up && enable |=> link_up);

  a_r5_set_bits: assert property (@(posedge clk) disable iff (rst)
    phy_req && phy_we && !ovrd_on |-> phy_wdata[5] && phy_wdata[3]);

  a_r6_clear_bits: assert property (@(posedge clk) disable iff (rst)
    phy_req && phy_we && ovrd_on |-> !phy_wdata[5] && !phy_wdata[3]);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(link_up && fail));

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    fail && enable |=> fail);

  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !train_en && !link_up && !fail && !ovrd_on && !phy_req);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    phy_req && !phy_ack && enable |=> phy_req && $stable(phy_we) && $stable(phy_wdata));

  a_r9_addr: assert property (@(posedge clk) disable iff (rst)
    phy_req |-> phy_addr == OVRD_ADDR);
endmodule

bind lt_stall_mon lt_stall_mon_chk #(
  .PHY_AW(PHY_AW), .PHY_DW(PHY_DW), .OVRD_ADDR(OVRD_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .link_cap_in(link_cap_in),
  .cap_wr(cap_wr), .link_cap_out(link_cap_out), .train_en(train_en),
  .link_up(link_up), .fail(fail), .ovrd_on(ovrd_on), .phy_req(phy_req),
  .phy_we(phy_we), .phy_ack(phy_ack), .phy_addr(phy_addr), .phy_wdata(phy_wdata)
);

// File: tb/lt_stall_mon_test.sv
module lt_stall_mon_test;
  localparam int CLK_HZ = 2_000_000;
  localparam int POLL_US = 10;
  localparam int HOLD_US = 40;
  localparam int MAX_POLLS = 16;
  localparam int CPU = CLK_HZ / 1_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [31:0] link_cap_in = '0, dbg_word0 = '0, dbg_word1 = '0;
  logic        rx_valid = 1'b1;
  logic        phy_ack;
  logic [15:0] phy_rdata;
  logic        cap_wr, train_en, link_up, fail, ovrd_on, phy_req, phy_we;
  logic [31:0] link_cap_out;
  logic [15:0] phy_addr, phy_wdata;

  int n_chk = 0, n_fail = 0;

  lt_stall_mon #(.CLK_HZ(CLK_HZ), .POLL_US(POLL_US), .HOLD_US(HOLD_US),
                 .MAX_POLLS(MAX_POLLS)) uut (
    .clk(clk), .rst(rst), .enable(enable), .link_cap_in(link_cap_in),
    .dbg_word0(dbg_word0), .dbg_word1(dbg_word1), .rx_valid(rx_valid),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata), .cap_wr(cap_wr),
    .link_cap_out(link_cap_out), .train_en(train_en), .link_up(link_up),
    .fail(fail), .ovrd_on(ovrd_on), .phy_req(phy_req), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata)
  );

  always #5 clk = ~clk;

  // PHY register model
  logic [15:0] preg, seed_val = '0;
  logic        seed_load = 1'b0;
  logic [15:0] wlog [0:63];
  int          wcnt = 0, reqc = 0, bad_addr = 0;

  always @(posedge clk) begin
    if (phy_req) reqc <= reqc + 1;
    if (rst) begin
      phy_ack <= 1'b0; phy_rdata <= '0; preg <= '0;
    end else if (seed_load) begin
      preg <= seed_val; phy_ack <= 1'b0;
    end else if (phy_req && !phy_ack) begin
      phy_ack   <= 1'b1;
      phy_rdata <= preg;
      if (phy_addr != 16'h1005) bad_addr <= bad_addr + 1;
      if (phy_we) begin
        preg <= phy_wdata;
        wlog[wcnt % 64] <= phy_wdata;
        wcnt <= wcnt + 1;
      end
    end else phy_ack <= 1'b0;
  end

  function automatic logic [31:0] exp_cap(input logic [31:0] c);
    return {c[31:4], 4'd1};
  endfunction
  function automatic logic [15:0] exp_set(input logic [15:0] v);
    return v | 16'h0028;
  endfunction
  function automatic logic [15:0] exp_clr(input logic [15:0] v);
    return v & ~16'h0028;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seed_reg(input logic [15:0] v);
    seed_val = v; seed_load = 1'b1; cyc(1); seed_load = 1'b0;
  endtask

  // enable and check R1 pulse
  task automatic start_mon(input logic [31:0] cap);
    link_cap_in = cap;
    enable = 1'b1;
    cyc(1);
    chk(cap_wr === 1'b1 && link_cap_out === exp_cap(cap), "R1 cap write",
        link_cap_out, exp_cap(cap));
    cyc(1);
    chk(cap_wr === 1'b0 && train_en === 1'b1, "R1 train_en", {cap_wr, train_en}, 2'b01);
  endtask

  task automatic stop_mon();
    enable = 1'b0;
    cyc(2);
    chk({train_en, link_up, fail, ovrd_on, phy_req} === 5'b0, "R8 idle",
        {train_en, link_up, fail, ovrd_on, phy_req}, 0);
  endtask

  task automatic bring_up();
    int w = 0;
    dbg_word1 = ($urandom & ~(32'h1 << 29)) | 32'h10;
    while (!link_up && w < 80) begin cyc(1); w++; end
    chk(link_up === 1'b1 && fail === 1'b0, "R2 link up", {link_up, fail}, 2'b10);
  endtask

  task automatic stall_case();
    logic [15:0] sv;
    logic [15:0] sval;
    int w, base, dur;
    sv = 16'($urandom);
    seed_reg(sv);
    base = wcnt;
    dbg_word1 = $urandom & ~32'h10;
    dbg_word0 = ($urandom & ~32'h3f) | 32'h0D;
    rx_valid = 1'b0;
    start_mon($urandom);
    w = 0;
    while (!ovrd_on && w < 200) begin cyc(1); w++; end
    sval = exp_set(sv);
    chk(wcnt == base + 1 && wlog[base % 64] === sval, "R5 set write",
        {16'(wcnt - base), wlog[base % 64]}, {16'd1, sval});
    dbg_word0 = 32'h11;
    dur = 0;
    while (ovrd_on && dur < 400) begin cyc(1); dur++; end
    chk(dur >= HOLD_US * CPU && dur <= HOLD_US * CPU + 10, "R6 hold length",
        dur, HOLD_US * CPU);
    chk(wcnt == base + 2 && wlog[(base + 1) % 64] === exp_clr(sval), "R6 clear write",
        wlog[(base + 1) % 64], exp_clr(sval));
    rx_valid = 1'b1;
    bring_up();
    chk(bad_addr == 0, "R9 address", bad_addr, 0);
    stop_mon();
  endtask

  task automatic quiet_case(input bit use_code);
    int rb;
    if (use_code) begin
      logic [5:0] c;
      c = 6'($urandom);
      if (c == 6'h0D) c = 6'h0E;
      dbg_word0 = ($urandom & ~32'h3f) | 32'(c);
      rx_valid = 1'b0;
    end else begin
      dbg_word0 = ($urandom & ~32'h3f) | 32'h0D;
      rx_valid = 1'b1;
    end
    dbg_word1 = $urandom | (32'h1 << 29);
    start_mon($urandom);
    rb = reqc;
    cyc(5 * (POLL_US * CPU + 3));
    chk(reqc == rb, "R4 no PHY access", reqc - rb, 0);
    chk(link_up === 1'b0, "R2 in-training not up", link_up, 0);
    bring_up();
    stop_mon();
  endtask

  // watchdog
  initial begin
    repeat (150_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd1234));
    cyc(3);
    chk({cap_wr, train_en, link_up, fail, ovrd_on, phy_req} === 6'b0, "R8 reset state",
        {cap_wr, train_en, link_up, fail, ovrd_on, phy_req}, 0);
    rst = 1'b0;
    cyc(2);

    // R7: timeout without link-up; R3 poll spacing bounds the fail time
    dbg_word0 = 32'h0; dbg_word1 = 32'h0; rx_valid = 1'b1;
    start_mon(32'hFFFF_FFF3);
    t = 2;
    while (!fail && t < 1000) begin cyc(1); t++; end
    chk(fail === 1'b1 && link_up === 1'b0, "R7 fail set", {fail, link_up}, 2'b10);
    chk(t >= MAX_POLLS * POLL_US * CPU && t <= MAX_POLLS * (POLL_US * CPU + 4) + 10,
        "R3 poll spacing", t, MAX_POLLS * POLL_US * CPU);
    dbg_word1 = 32'h10;
    cyc(60);
    chk(fail === 1'b1 && link_up === 1'b0, "R7 fail sticky", {fail, link_up}, 2'b10);
    stop_mon();

    // R2: link up on first poll, and time of first poll
    dbg_word1 = 32'h0000_0010;
    start_mon(32'h0);
    t = 0;
    while (!link_up && t < 100) begin cyc(1); t++; end
    chk(t >= POLL_US * CPU - 2 && t <= POLL_US * CPU + 4, "R3 first poll", t, POLL_US * CPU);
    stop_mon();

    // directed stall, then random mix
    stall_case();
    for (int i = 0; i < 12; i++) begin
      case ($urandom % 3)
        0: stall_case();
        1: quiet_case(1'b1);
        default: quiet_case(1'b0);
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule